// File: doc/BRIEF.md
# Critical-Section Line Tracking Buffers

This block sits beside a first-level data cache and makes short synchronized regions cheap to close. While a region is open, it keeps a list of every cache position (set index and way) the core has written. When the region closes, it replays one writeback request per listed position, so the cache controller does not have to sweep the whole array. If more distinct positions are written than the list can hold, the block falls back to a single whole-cache writeback request.

A second, smaller list holds the tags of lines already self-invalidated inside the open region. Self-invalidation requests from the core pass through this filter. A request whose tag is already listed is suppressed. Any other request is issued and its tag is recorded while room remains. Outside a region every request passes through unfiltered. Opening a region empties both lists.

The controller is a six-state machine:
- `ST_IDLE` goes to `ST_ACTIVE` on region begin.
- `ST_ACTIVE` restarts itself on a repeated begin and goes to `ST_CLOSE` on region end.
- `ST_CLOSE` picks one of three exits:
  - `ST_FLUSH` when the write list has overflowed.
  - `ST_DONE` when the write list is empty.
  - `ST_REPLAY` otherwise.
- `ST_REPLAY` steps through the list and goes to `ST_DONE` after the last entry.
- `ST_FLUSH` goes to `ST_DONE` after one cycle.
- `ST_DONE` returns to `ST_IDLE` after one cycle.

Top module: `cs_track_buf`

## Requirements
- R1: After reset, `wb_valid`, `wb_all` and `wb_done` are 0, and no earlier write is replayed by a later empty region.
- R2: Each distinct (set, way) written while a region is open, including in the cycle `region_end` is high, is replayed exactly once. Replay follows the order of first write, one per cycle. The first request appears two cycles after the cycle in which `region_end` is high.
- R3: Repeated writes to the same (set, way) within one region produce a single replay.
- R4: Writes made while no region is open are not recorded.
- R5: Exactly WR_DEPTH (16) distinct positions replay individually, with no fallback.
- R6: More than WR_DEPTH distinct positions produce exactly one `wb_all` cycle and no `wb_valid` cycle. The `wb_all` cycle is two cycles after the `region_end` cycle.
- R7: `wb_done` pulses for exactly one cycle. It comes in the cycle after the last request, or two cycles after the `region_end` cycle when nothing was written.
- R8: Inside an open region, an invalidate request whose tag is already recorded gives `inv_issue`=0. A new tag gives `inv_issue`=1, combinationally in the same cycle.
- R9: The invalidate list holds INV_DEPTH (4) tags. Further new tags are issued but not recorded, so repeating them issues them again, while the first four stay filtered.
- R10: Region begin empties both lists. A tag recorded in an earlier region is issued again, and earlier writes are not replayed.
- R11: While no region is open, every invalidate request is issued (`inv_issue` equals `inv_req`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| region_begin | input | 1 | Opens (or restarts) a tracked region |
| region_end | input | 1 | Closes the open region and starts replay |
| wr_valid | input | 1 | Core wrote a cache line this cycle |
| wr_set | input | SET_W | Set index of the written line |
| wr_way | input | WAY_W | Way of the written line |
| inv_req | input | 1 | Core asks to self-invalidate a line |
| inv_tag | input | TAG_W | Line address of that request |
| inv_issue | output | 1 | Invalidation must be performed |
| wb_valid | output | 1 | Writeback request for one position |
| wb_set | output | SET_W | Set index of the requested writeback |
| wb_way | output | WAY_W | Way of the requested writeback |
| wb_all | output | 1 | Whole-cache writeback request (overflow fallback) |
| wb_done | output | 1 | One-cycle pulse when region-close work is finished |

## Verification
The bench builds the block with its defaults: 6 set bits, 2 way bits, 16 tag bits, 16 write entries and 4 invalidate entries. Random regions draw positions from a pool of 24 (six sets, four ways) with up to 22 writes each. This produces duplicates often and pushes past the 16-entry limit in a fair share of regions, so both replay and fallback paths run many times. Invalidate tags come from a pool of eight. The 4-entry list therefore fills quickly, and suppressed, recorded and unrecorded requests all occur within one region.

// File: rtl/cs_trk_pkg.sv
package cs_trk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_CLOSE,
        ST_REPLAY,
        ST_FLUSH,
        ST_DONE
    } trk_state_e;
endpackage

// File: rtl/cs_wpos_buf.sv
module cs_wpos_buf #(
    parameter int SET_W = 6,
    parameter int WAY_W = 2,
    parameter int DEPTH = 16,
    localparam int POS_W = SET_W + WAY_W,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             rec_en,
    input  logic [SET_W-1:0] in_set,
    input  logic [WAY_W-1:0] in_way,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [SET_W-1:0] rd_set,
    output logic [WAY_W-1:0] rd_way,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    logic [POS_W-1:0] pos_q [DEPTH];
    logic [DEPTH-1:0] hit_vec;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic [POS_W-1:0] in_pos;
    logic             hit;
    logic             full;

    assign in_pos = {in_set, in_way};
    assign full   = (cnt_q == CNT_W'(DEPTH));

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit_vec[i] = (CNT_W'(i) < cnt_q) && (pos_q[i] == in_pos);
    end
    assign hit = |hit_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (clr) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (rec_en && !hit) begin
            if (!full) cnt_q <= cnt_q + CNT_W'(1);
            else       ovf_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!clr && rec_en && !hit && !full)
            pos_q[cnt_q[IDX_W-1:0]] <= in_pos;
    end

    assign {rd_set, rd_way} = pos_q[rd_idx];
    assign cnt = cnt_q;
    assign ovf = ovf_q;

    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
    a_r6_ovf_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> ($past(cnt_q) == CNT_W'(DEPTH)));
    a_r2_grow_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));
    a_r3_dup_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && rec_en && hit) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/cs_itag_buf.sv
module cs_itag_buf #(
    parameter int TAG_W = 16,
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             track,
    input  logic             req,
    input  logic [TAG_W-1:0] tag,
    output logic             issue
);
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [DEPTH-1:0] hit_vec;
    logic [CNT_W-1:0] cnt_q;
    logic             hit;
    logic             store;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit_vec[i] = (CNT_W'(i) < cnt_q) && (tag_q[i] == tag);
    end
    assign hit   = |hit_vec;
    assign issue = req && !(track && hit);
    assign store = track && req && !hit && (cnt_q < CNT_W'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr)   cnt_q <= '0;
        else if (store) cnt_q <= cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!clr && store) tag_q[cnt_q[IDX_W-1:0]] <= tag;
    end

    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
    a_r11_no_record_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (!track && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/cs_trk_ctrl.sv
module cs_trk_ctrl
    import cs_trk_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             region_begin,
    input  logic             region_end,
    input  logic [CNT_W-1:0] wcnt,
    input  logic             wovf,
    output logic             clr,
    output logic             track,
    output logic [IDX_W-1:0] rep_idx,
    output logic             wb_valid,
    output logic             wb_all,
    output logic             wb_done,
    output trk_state_e       state
);
    trk_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             last;

    assign last = (CNT_W'(idx_q) + CNT_W'(1)) == wcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_REPLAY) idx_q <= idx_q + IDX_W'(1);
            else                      idx_q <= '0;
        end
    end

    always_comb begin
        state_d  = state_q;
        clr      = 1'b0;
        track    = 1'b0;
        wb_valid = 1'b0;
        wb_all   = 1'b0;
        wb_done  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                clr = region_begin;
                if (region_begin) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                clr   = region_begin;
                track = !region_begin;
                if (!region_begin && region_end) state_d = ST_CLOSE;
            end
            ST_CLOSE: begin
                if (wovf)                 state_d = ST_FLUSH;
                else if (wcnt == '0)      state_d = ST_DONE;
                else                      state_d = ST_REPLAY;
            end
            ST_REPLAY: begin
                wb_valid = 1'b1;
                if (last) state_d = ST_DONE;
            end
            ST_FLUSH: begin
                wb_all  = 1'b1;
                state_d = ST_DONE;
            end
            ST_DONE: begin
                wb_done = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign rep_idx = idx_q;
    assign state   = state_q;

    a_r6_flush_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_valid && wb_all));
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wb_done |=> !wb_done);
    a_r2_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (CNT_W'(idx_q) < wcnt));
    a_r7_done_after_replay: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wb_valid) |-> wb_done);
endmodule

// File: rtl/cs_track_buf.sv
module cs_track_buf
    import cs_trk_pkg::*;
#(
    parameter int SET_W     = 6,
    parameter int WAY_W     = 2,
    parameter int TAG_W     = 16,
    parameter int WR_DEPTH  = 16,
    parameter int INV_DEPTH = 4,
    localparam int WCNT_W   = $clog2(WR_DEPTH + 1),
    localparam int WIDX_W   = $clog2(WR_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             region_begin,
    input  logic             region_end,
    input  logic             wr_valid,
    input  logic [SET_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_way,
    input  logic             inv_req,
    input  logic [TAG_W-1:0] inv_tag,
    output logic             inv_issue,
    output logic             wb_valid,
    output logic [SET_W-1:0] wb_set,
    output logic [WAY_W-1:0] wb_way,
    output logic             wb_all,
    output logic             wb_done
);
    logic              clr, track;
    logic [WIDX_W-1:0] rep_idx;
    logic [WCNT_W-1:0] wcnt;
    logic              wovf;
    trk_state_e        state;

    cs_trk_ctrl #(.CNT_W(WCNT_W), .IDX_W(WIDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .region_begin(region_begin), .region_end(region_end),
        .wcnt(wcnt), .wovf(wovf),
        .clr(clr), .track(track), .rep_idx(rep_idx),
        .wb_valid(wb_valid), .wb_all(wb_all), .wb_done(wb_done),
        .state(state)
    );

    cs_wpos_buf #(.SET_W(SET_W), .WAY_W(WAY_W), .DEPTH(WR_DEPTH)) u_wpos (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .rec_en(track && wr_valid),
        .in_set(wr_set), .in_way(wr_way),
        .rd_idx(rep_idx), .rd_set(wb_set), .rd_way(wb_way),
        .cnt(wcnt), .ovf(wovf)
    );

    cs_itag_buf #(.TAG_W(TAG_W), .DEPTH(INV_DEPTH)) u_itag (
        .clk(clk), .rst_n(rst_n), .clr(clr), .track(track),
        .req(inv_req), .tag(inv_tag), .issue(inv_issue)
    );

    a_r11_pass_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_ACTIVE) |-> (inv_issue == inv_req));
    a_r6_no_replay_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLOSE && wovf) |=> (wb_all && !wb_valid));
endmodule

// File: tb/cs_track_buf_tb.sv
`timescale 1ns/1ps
module cs_track_buf_tb;
    localparam int SET_W = 6, WAY_W = 2, TAG_W = 16, WD = 16, ID = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic region_begin = 0, region_end = 0, wr_valid = 0, inv_req = 0;
    logic [SET_W-1:0] wr_set = '0;
    logic [WAY_W-1:0] wr_way = '0;
    logic [TAG_W-1:0] inv_tag = '0;
    logic inv_issue, wb_valid, wb_all, wb_done;
    logic [SET_W-1:0] wb_set;
    logic [WAY_W-1:0] wb_way;

    always #10 clk = ~clk;

    cs_track_buf u_dut (
        .clk(clk), .rst_n(rst_n), .region_begin(region_begin), .region_end(region_end),
        .wr_valid(wr_valid), .wr_set(wr_set), .wr_way(wr_way),
        .inv_req(inv_req), .inv_tag(inv_tag), .inv_issue(inv_issue),
        .wb_valid(wb_valid), .wb_set(wb_set), .wb_way(wb_way),
        .wb_all(wb_all), .wb_done(wb_done)
    );

    int nchk = 0, nfail = 0;
    bit in_reg = 0;
    logic [SET_W+WAY_W-1:0] mpos [WD];
    int  mwcnt = 0;
    bit  mwovf = 0;
    logic [TAG_W-1:0] mtag [ID];
    int  micnt = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit wpos_known(logic [SET_W+WAY_W-1:0] p);
        for (int i = 0; i < mwcnt; i++) if (mpos[i] == p) return 1;
        return 0;
    endfunction

    function automatic bit tag_known(logic [TAG_W-1:0] t);
        for (int i = 0; i < micnt; i++) if (mtag[i] == t) return 1;
        return 0;
    endfunction

    task automatic drive_idle();
        region_begin = 0; region_end = 0; wr_valid = 0; inv_req = 0;
    endtask

    task automatic begin_region();
        @(negedge clk); drive_idle(); region_begin = 1;
        in_reg = 1; mwcnt = 0; mwovf = 0; micnt = 0;
    endtask

    task automatic wr_cycle(int s, int w);
        logic [SET_W+WAY_W-1:0] p;
        @(negedge clk); drive_idle();
        wr_valid = 1; wr_set = SET_W'(s); wr_way = WAY_W'(w);
        p = {SET_W'(s), WAY_W'(w)};
        if (in_reg && !wpos_known(p)) begin
            if (mwcnt < WD) begin mpos[mwcnt] = p; mwcnt++; end
            else mwovf = 1;
        end
    endtask

    task automatic inv_probe(int t, string req);
        bit exp;
        @(negedge clk); drive_idle();
        inv_req = 1; inv_tag = TAG_W'(t);
        exp = !(in_reg && tag_known(TAG_W'(t)));
        #5 chk(req, {31'd0, inv_issue}, {31'd0, exp});
        if (in_reg && exp && micnt < ID) begin mtag[micnt] = TAG_W'(t); micnt++; end
    endtask

    // close the region; expected replay follows R2/R6/R7 timing
    task automatic end_and_check();
        @(negedge clk); drive_idle(); region_end = 1; in_reg = 0;
        @(negedge clk); drive_idle();
        #1 chk("R2 close cycle quiet", {30'd0, wb_valid, wb_done}, 32'd0);
        if (mwovf) begin
            @(negedge clk); #1
            chk("R6 fallback", {30'd0, wb_all, wb_valid}, 32'd2);
        end else begin
            for (int k = 0; k < mwcnt; k++) begin
                @(negedge clk); #1
                chk("R2 replay valid", {31'd0, wb_valid}, 32'd1);
                chk("R2 replay position", {24'd0, wb_set, wb_way}, {24'd0, mpos[k]});
                chk("R6 no fallback", {31'd0, wb_all}, 32'd0);
            end
        end
        @(negedge clk); #1
        chk("R7 done", {29'd0, wb_done, wb_valid, wb_all}, 32'd4);
        @(negedge clk); #1
        chk("R7 done one cycle", {31'd0, wb_done}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        #1 chk("R1 reset outputs", {29'd0, wb_valid, wb_all, wb_done}, 32'd0);
        rst_n = 1;

        // R4: writes outside a region, then an empty region -> only done
        wr_cycle(3, 1); wr_cycle(5, 2);
        begin_region(); end_and_check();

        // R2 / R3: ordered replay with duplicates
        begin_region();
        wr_cycle(7, 0); wr_cycle(2, 3); wr_cycle(7, 0); wr_cycle(9, 1); wr_cycle(2, 3);
        end_and_check();

        // R5: exactly sixteen distinct positions
        begin_region();
        for (int i = 0; i < WD; i++) wr_cycle(i, i % 4);
        end_and_check();

        // R6: seventeen distinct positions
        begin_region();
        for (int i = 0; i < WD + 1; i++) wr_cycle(i + 20, 1);
        end_and_check();

        // R10: previous writes not replayed after new begin
        begin_region(); wr_cycle(1, 1);
        begin_region(); end_and_check();

        // R8 / R9 / R10 / R11: invalidate filter
        begin_region();
        inv_probe(16'h10, "R8 first tag issued");
        inv_probe(16'h10, "R8 repeat suppressed");
        inv_probe(16'h11, "R8 new tag issued");
        inv_probe(16'h12, "R9 fill");
        inv_probe(16'h13, "R9 fill");
        inv_probe(16'h14, "R9 fifth issued");
        inv_probe(16'h14, "R9 unrecorded reissued");
        inv_probe(16'h13, "R9 recorded still filtered");
        end_and_check();
        inv_probe(16'h10, "R11 outside region passes");
        begin_region();
        inv_probe(16'h10, "R10 cleared tag issued again");
        end_and_check();

        // random regions mixing writes and invalidates
        for (int r = 0; r < 60; r++) begin
            int nw;
            begin_region();
            nw = $urandom_range(0, 22);
            for (int i = 0; i < nw; i++) begin
                wr_cycle($urandom_range(0, 5), $urandom_range(0, 3));
                if ($urandom_range(0, 2) == 0)
                    inv_probe($urandom_range(0, 7), "R8 random invalidate");
            end
            end_and_check();
            if ($urandom_range(0, 1) == 0) begin
                wr_cycle($urandom_range(0, 5), $urandom_range(0, 3));
                inv_probe($urandom_range(0, 7), "R11 random outside");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule